// File: doc/BRIEF.md
# RGB White-Balance, Knee and Gamma Pipeline

This block takes one red, green and blue sample per clock, as produced by an upstream colour separation step, and shapes it for display in four registered stages. The first stage applies white-balance gain to the red and blue channels only; green goes through unchanged. The second stage adds a signed black-level offset to every channel. The third stage applies a single soft-compression knee, with one knee point and one slope shared by all three channels. The fourth stage maps each channel through a programmable piecewise-linear gamma curve.

All settings are static configuration inputs. The gamma curve is held as 17 breakpoints of 10 bits each. A straight line gives a linear curve; points sampled from a 0.35-power law give strong gamma compression. Every stage saturates to the 10-bit range and never wraps. A valid flag travels with each pixel, and the latency is fixed at four cycles.

Top module: `rgb_tone_pipe`

## Requirements
- R1: Gains are unsigned, with 2 integer and 6 fraction bits (64 means 1.0). Red becomes min(1023, floor(R·gain_r/64)) and blue becomes min(1023, floor(B·gain_b/64)). Green passes through the gain stage unchanged.
- R2: The signed 11-bit black offset is added to all three channels after the gain stage. The result is clamped to the range 0..1023.
- R3: Call the offset result x. If x ≤ knee_pt, the knee outputs x. Otherwise it outputs min(1023, knee_pt + floor((x−knee_pt)·slope/128)), where slope is unsigned with 1 integer and 7 fraction bits. The same knee point and slope apply to all three channels.
- R4: The gamma stage splits its input x into seg = x[9:6] and f = x[5:0]. The output is bp[seg] + floor((bp[seg+1]−bp[seg])·f/64), clamped to 0..1023. Breakpoint i sits in bits [10i+9:10i] of the breakpoint vector, for i = 0..16. Falling segments are allowed.
- R5: Each output sample and out_valid appear exactly 4 clock cycles after the matching input sample and in_valid.
- R6: While reset is asserted, out_valid and all three outputs are 0.
- R7: A breakpoint table sampled from a 0.35-power law, bp[i] = round(1023·(i/16)^0.35), can be loaded. The block then produces the R4 interpolation of that curve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_gain_r | input | 8 | Red white-balance gain, 2.6 unsigned |
| cfg_gain_b | input | 8 | Blue white-balance gain, 2.6 unsigned |
| cfg_black | input | 11 | Signed black offset added to all channels |
| cfg_knee_pt | input | 10 | Knee point |
| cfg_knee_slope | input | 8 | Slope above the knee point, 1.7 unsigned |
| cfg_gamma_bp | input | 170 | 17 packed 10-bit gamma breakpoints, point 0 in the low bits |
| in_valid | input | 1 | Input sample valid |
| in_r | input | 10 | Red input |
| in_g | input | 10 | Green input |
| in_b | input | 10 | Blue input |
| out_valid | output | 1 | Output sample valid |
| out_r | output | 10 | Red output |
| out_g | output | 10 | Green output |
| out_b | output | 10 | Blue output |

## Verification
Each stage's assertions compare that stage's registered result with the configuration value sampled on the edge that loaded the pixel. They therefore assume that the inputs are known, two-state values at every clock edge once reset has been released. The knee bound (output never above input) is only claimed while the slope is at most 1.0. The bench changes configuration only after it has drained the pipeline with four idle cycles. As a result, every valid pixel sees one coherent set of settings, and the reference model can use the settings that were current when the pixel was pushed. Random pixels are mixed with the extremes 0, 1023 and each knee point, so that every saturation path is reached.

// File: rtl/rgbtone_pkg.sv
package rgbtone_pkg;
    localparam int PIX_W      = 10;
    localparam int PIX_MAX    = (1 << PIX_W) - 1;
    localparam int GAIN_W     = 8;
    localparam int GAIN_FRAC  = 6;
    localparam int OFS_W      = 11;
    localparam int SLOPE_W    = 8;
    localparam int SLOPE_FRAC = 7;
    localparam int SEG_LOG2   = 4;
    localparam int NSEG       = 1 << SEG_LOG2;
    localparam int NBP        = NSEG + 1;
    localparam int FRAC_W     = PIX_W - SEG_LOG2;
    localparam int BP_BITS    = NBP * PIX_W;
    localparam int NCH        = 3;
    localparam int CH_R       = 0;
    localparam int CH_G       = 1;
    localparam int CH_B       = 2;
    localparam int LATENCY    = 4;

    typedef logic [PIX_W-1:0] pix_t;
    typedef pix_t [NCH-1:0] trio_t;
endpackage

// File: rtl/rgbtone_wb.sv
module rgbtone_wb
    import rgbtone_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  trio_t               in_px,
    input  logic [GAIN_W-1:0]   gain_r,
    input  logic [GAIN_W-1:0]   gain_b,
    output logic                out_valid,
    output trio_t               out_px
);
    localparam int MW = PIX_W + GAIN_W;

    typedef struct packed {
        logic  vld;
        logic  started;
        trio_t px;
    } wb_st_t;

    wb_st_t s_d, s_q;
    logic [MW-1:0] prod   [NCH];
    logic [MW-1:0] scaled [NCH];

    always_comb begin
        s_d         = s_q;
        s_d.vld     = in_valid;
        s_d.started = 1'b1;
        for (int ch = 0; ch < NCH; ch++) begin
            prod[ch]   = MW'(in_px[ch]) * MW'((ch == CH_R) ? gain_r : gain_b);
            scaled[ch] = prod[ch] >> GAIN_FRAC;
            if (ch == CH_G)
                s_d.px[ch] = in_px[ch];
            else if (scaled[ch] > MW'(PIX_MAX))
                s_d.px[ch] = pix_t'(PIX_MAX);
            else
                s_d.px[ch] = scaled[ch][PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_px    = s_q.px;

    AST_GREEN_UNGAINED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.started |-> out_px[CH_G] == $past(in_px[CH_G])); // R1

    AST_RED_UNITY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.started && $past(gain_r) <= GAIN_W'(1 << GAIN_FRAC))
            |-> out_px[CH_R] <= $past(in_px[CH_R])); // R1
endmodule

// File: rtl/rgbtone_ofs.sv
module rgbtone_ofs
    import rgbtone_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  trio_t                   in_px,
    input  logic signed [OFS_W-1:0] black,
    output logic                    out_valid,
    output trio_t                   out_px
);
    localparam int SW = PIX_W + 2;

    typedef struct packed {
        logic  vld;
        logic  started;
        trio_t px;
    } ofs_st_t;

    ofs_st_t s_d, s_q;
    logic signed [SW-1:0] sum [NCH];

    always_comb begin
        s_d         = s_q;
        s_d.vld     = in_valid;
        s_d.started = 1'b1;
        for (int ch = 0; ch < NCH; ch++) begin
            sum[ch] = $signed({2'b00, in_px[ch]}) + SW'(black);
            if (sum[ch] < 0)
                s_d.px[ch] = '0;
            else if (sum[ch] > $signed(SW'(PIX_MAX)))
                s_d.px[ch] = pix_t'(PIX_MAX);
            else
                s_d.px[ch] = sum[ch][PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_px    = s_q.px;

    AST_ZERO_OFFSET_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.started && $past(black) == '0) |-> out_px == $past(in_px)); // R2

    AST_NEG_OFFSET_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.started && $past(black) < 0) |-> out_px[CH_G] <= $past(in_px[CH_G])); // R2
endmodule

// File: rtl/rgbtone_knee.sv
module rgbtone_knee
    import rgbtone_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  trio_t               in_px,
    input  pix_t                knee_pt,
    input  logic [SLOPE_W-1:0]  slope,
    output logic                out_valid,
    output trio_t               out_px
);
    localparam int KW = PIX_W + SLOPE_W;

    typedef struct packed {
        logic  vld;
        logic  started;
        trio_t px;
    } knee_st_t;

    knee_st_t s_d, s_q;
    pix_t          over  [NCH];
    logic [KW-1:0] kprod [NCH];
    logic [KW:0]   ksum  [NCH];

    always_comb begin
        s_d         = s_q;
        s_d.vld     = in_valid;
        s_d.started = 1'b1;
        for (int ch = 0; ch < NCH; ch++) begin
            over[ch]  = (in_px[ch] > knee_pt) ? (in_px[ch] - knee_pt) : '0;
            kprod[ch] = KW'(over[ch]) * KW'(slope);
            ksum[ch]  = (KW+1)'(knee_pt) + (KW+1)'(kprod[ch] >> SLOPE_FRAC);
            if (in_px[ch] <= knee_pt)
                s_d.px[ch] = in_px[ch];
            else if (ksum[ch] > (KW+1)'(PIX_MAX))
                s_d.px[ch] = pix_t'(PIX_MAX);
            else
                s_d.px[ch] = ksum[ch][PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_px    = s_q.px;

    for (genvar c = 0; c < NCH; c++) begin : g_knee_chk
        AST_KNEE_BELOW_POINT: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.started && $past(in_px[c]) <= $past(knee_pt))
                |-> out_px[c] == $past(in_px[c])); // R3
        AST_KNEE_COMPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.started && $past(slope) <= SLOPE_W'(1 << SLOPE_FRAC))
                |-> out_px[c] <= $past(in_px[c])); // R3
    end
endmodule

// File: rtl/rgbtone_gamma.sv
module rgbtone_gamma
    import rgbtone_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  trio_t               in_px,
    input  logic [BP_BITS-1:0]  bp_flat,
    output logic                out_valid,
    output trio_t               out_px
);
    localparam int DW = PIX_W + 1;
    localparam int GW = DW + FRAC_W + 1;
    localparam int YW = GW + 1;

    typedef struct packed {
        logic  vld;
        logic  started;
        trio_t px;
    } gam_st_t;

    gam_st_t s_d, s_q;
    pix_t                  bp    [NBP];
    logic [SEG_LOG2-1:0]   seg   [NCH];
    logic [FRAC_W-1:0]     frac  [NCH];
    pix_t                  lo    [NCH];
    pix_t                  hi    [NCH];
    logic signed [DW-1:0]  diff  [NCH];
    logic signed [GW-1:0]  prod  [NCH];
    logic signed [GW-1:0]  step  [NCH];
    logic signed [YW-1:0]  ysum  [NCH];

    for (genvar i = 0; i < NBP; i++) begin : g_bp
        assign bp[i] = bp_flat[i*PIX_W +: PIX_W];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_split
        assign seg[c]  = in_px[c][PIX_W-1:FRAC_W];
        assign frac[c] = in_px[c][FRAC_W-1:0];
    end

    always_comb begin
        s_d         = s_q;
        s_d.vld     = in_valid;
        s_d.started = 1'b1;
        for (int ch = 0; ch < NCH; ch++) begin
            lo[ch]   = bp[int'(seg[ch])];
            hi[ch]   = bp[int'(seg[ch]) + 1];
            diff[ch] = $signed({1'b0, hi[ch]}) - $signed({1'b0, lo[ch]});
            prod[ch] = GW'(diff[ch]) * $signed(GW'({1'b0, frac[ch]}));
            step[ch] = prod[ch] >>> FRAC_W;
            ysum[ch] = YW'(step[ch]) + $signed(YW'({1'b0, lo[ch]}));
            if (ysum[ch] < 0)
                s_d.px[ch] = '0;
            else if (ysum[ch] > $signed(YW'(PIX_MAX)))
                s_d.px[ch] = pix_t'(PIX_MAX);
            else
                s_d.px[ch] = ysum[ch][PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_px    = s_q.px;

    for (genvar c = 0; c < NCH; c++) begin : g_gam_chk
        AST_GAMMA_HITS_KNOT: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.started && $past(frac[c]) == '0)
                |-> out_px[c] == $past(bp[seg[c]])); // R4
    end
endmodule

// File: rtl/rgb_tone_pipe.sv
module rgb_tone_pipe
    import rgbtone_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              cfg_gain_r,
    input  logic [7:0]              cfg_gain_b,
    input  logic signed [10:0]      cfg_black,
    input  logic [9:0]              cfg_knee_pt,
    input  logic [7:0]              cfg_knee_slope,
    input  logic [169:0]            cfg_gamma_bp,
    input  logic                    in_valid,
    input  logic [9:0]              in_r,
    input  logic [9:0]              in_g,
    input  logic [9:0]              in_b,
    output logic                    out_valid,
    output logic [9:0]              out_r,
    output logic [9:0]              out_g,
    output logic [9:0]              out_b
);
    localparam int CW = $clog2(LATENCY + 1);

    trio_t in_trio, wb_px, ofs_px, knee_px, gam_px;
    logic  wb_v, ofs_v, knee_v, gam_v;

    assign in_trio[CH_R] = in_r;
    assign in_trio[CH_G] = in_g;
    assign in_trio[CH_B] = in_b;

    rgbtone_wb u_wb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_px(in_trio),
        .gain_r(cfg_gain_r), .gain_b(cfg_gain_b),
        .out_valid(wb_v), .out_px(wb_px)
    );

    rgbtone_ofs u_ofs (
        .clk(clk), .rst_n(rst_n), .in_valid(wb_v), .in_px(wb_px),
        .black(cfg_black), .out_valid(ofs_v), .out_px(ofs_px)
    );

    rgbtone_knee u_knee (
        .clk(clk), .rst_n(rst_n), .in_valid(ofs_v), .in_px(ofs_px),
        .knee_pt(cfg_knee_pt), .slope(cfg_knee_slope),
        .out_valid(knee_v), .out_px(knee_px)
    );

    rgbtone_gamma u_gamma (
        .clk(clk), .rst_n(rst_n), .in_valid(knee_v), .in_px(knee_px),
        .bp_flat(cfg_gamma_bp), .out_valid(gam_v), .out_px(gam_px)
    );

    assign out_valid = gam_v;
    assign out_r     = gam_px[CH_R];
    assign out_g     = gam_px[CH_G];
    assign out_b     = gam_px[CH_B];

    // cycles since reset, saturating, used only to qualify the latency check
    logic [CW-1:0] age_d, age_q;

    always_comb begin
        age_d = (age_q == CW'(LATENCY)) ? age_q : age_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        age_q == CW'(LATENCY) |-> out_valid == $past(in_valid, 4)); // R5
endmodule

// File: tb/rgb_tone_pipe_test.sv
`timescale 1ns/1ps
module rgb_tone_pipe_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n;
    logic [7:0]         cfg_gain_r, cfg_gain_b;
    logic signed [10:0] cfg_black;
    logic [9:0]         cfg_knee_pt;
    logic [7:0]         cfg_knee_slope;
    logic [169:0]       cfg_gamma_bp;
    logic               in_valid;
    logic [9:0]         in_r, in_g, in_b;
    logic               out_valid;
    logic [9:0]         out_r, out_g, out_b;

    rgb_tone_pipe uut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int bp_tab [17];

    typedef struct {
        bit    v;
        int    r, g, b;
        string tag;
    } exp_t;
    exp_t q [$];

    function automatic int clampi(int v);
        return (v < 0) ? 0 : (v > 1023) ? 1023 : v;
    endfunction

    function automatic int ref_chan(int x, bit gained, int gain);
        int y, seg, f, d;
        y = gained ? clampi((x * gain) >>> 6) : x;
        y = clampi(y + int'(cfg_black));
        if (y > int'(cfg_knee_pt))
            y = clampi(int'(cfg_knee_pt) + (((y - int'(cfg_knee_pt)) * int'(cfg_knee_slope)) >>> 7));
        seg = y >>> 6;
        f   = y & 63;
        d   = bp_tab[seg + 1] - bp_tab[seg];
        return clampi(bp_tab[seg] + ((d * f) >>> 6));
    endfunction

    task automatic load_bp();
        for (int i = 0; i < 17; i++) cfg_gamma_bp[i*10 +: 10] = 10'(bp_tab[i]);
    endtask

    task automatic compare();
        exp_t e;
        if (q.size() == 4) begin
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v) begin
                errors++;
                $display("FAIL R5 out_valid actual %0b expected %0b", out_valid, e.v);
            end
            if (e.v) begin
                checks++;
                if (out_r !== 10'(e.r) || out_g !== 10'(e.g) || out_b !== 10'(e.b)) begin
                    errors++;
                    $display("FAIL %s rgb actual %0d %0d %0d expected %0d %0d %0d",
                             e.tag, out_r, out_g, out_b, e.r, e.g, e.b);
                end
            end
        end
    endtask

    task automatic step(bit v, int r, int g, int b, string tag);
        exp_t e;
        @(negedge clk);
        compare();
        in_valid = v;
        in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
        e.v = v;
        e.r = ref_chan(r, 1, int'(cfg_gain_r));
        e.g = ref_chan(g, 0, 0);
        e.b = ref_chan(b, 1, int'(cfg_gain_b));
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R5");
    endtask

    task automatic burst(int n, string tag);
        for (int i = 0; i < n; i++)
            step(1, $urandom_range(1023), $urandom_range(1023), $urandom_range(1023), tag);
    endtask

    task automatic linear_bp();
        for (int i = 0; i < 17; i++) bp_tab[i] = (i == 16) ? 1023 : 64 * i;
        load_bp();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_r = '0; in_g = '0; in_b = '0;
        cfg_gain_r = 8'd64; cfg_gain_b = 8'd64; cfg_black = '0;
        cfg_knee_pt = 10'd1023; cfg_knee_slope = 8'd128;
        cfg_gamma_bp = '0;
        linear_bp();

        // R6: reset state, with a valid pixel presented during reset
        repeat (2) @(negedge clk);
        in_valid = 1'b1; in_r = 10'd700; in_g = 10'd300; in_b = 10'd900;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_r !== '0 || out_g !== '0 || out_b !== '0) begin
            errors++;
            $display("FAIL R6 reset outputs actual %0b %0d %0d %0d expected 0 0 0 0",
                     out_valid, out_r, out_g, out_b);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            exp_t e;
            e.v = 0; e.r = 0; e.g = 0; e.b = 0; e.tag = "R6";
            q.push_back(e);
        end

        // R4: unity settings and a linear curve
        burst(40, "R4");
        step(1, 0, 1023, 959, "R4");
        drain();

        // R1: white-balance gains, including saturation
        cfg_gain_r = 8'd128; cfg_gain_b = 8'd32;
        burst(40, "R1");
        step(1, 1023, 1023, 1023, "R1");
        drain();
        cfg_gain_r = 8'd255; cfg_gain_b = 8'd255;
        burst(20, "R1");
        step(1, 300, 5, 260, "R1");
        drain();
        cfg_gain_r = 8'd64; cfg_gain_b = 8'd64;

        // R2: black offset, clamping at both ends
        cfg_black = -11'sd200;
        burst(30, "R2");
        step(1, 150, 199, 200, "R2");
        drain();
        cfg_black = 11'sd400;
        burst(30, "R2");
        step(1, 623, 624, 1023, "R2");
        drain();
        cfg_black = -11'sd1024;
        step(1, 1023, 500, 0, "R2");
        drain();
        cfg_black = '0;

        // R3: knee with compressing and expanding slopes
        cfg_knee_pt = 10'd512; cfg_knee_slope = 8'd64;
        burst(40, "R3");
        step(1, 512, 513, 1023, "R3");
        drain();
        cfg_knee_pt = 10'd600; cfg_knee_slope = 8'd255;
        burst(30, "R3");
        step(1, 600, 900, 1023, "R3");
        drain();
        cfg_knee_pt = 10'd0; cfg_knee_slope = 8'd0;
        step(1, 0, 1, 1023, "R3");
        drain();
        cfg_knee_pt = 10'd1023; cfg_knee_slope = 8'd128;

        // R7: 0.35-power curve
        for (int i = 0; i < 17; i++)
            bp_tab[i] = $rtoi(1023.0 * $pow(real'(i) / 16.0, 0.35) + 0.5);
        load_bp();
        burst(40, "R7");
        step(1, 0, 64, 1023, "R7");
        drain();

        // R4: falling curve, negative interpolation steps
        for (int i = 0; i < 17; i++) bp_tab[i] = 1023 - 60 * i;
        load_bp();
        burst(30, "R4");
        step(1, 63, 960, 1023, "R4");
        drain();

        // R5: valid gaps with mixed settings
        linear_bp();
        cfg_gain_r = 8'd90; cfg_gain_b = 8'd50; cfg_black = 11'sd20;
        cfg_knee_pt = 10'd700; cfg_knee_slope = 8'd100;
        for (int i = 0; i < 60; i++)
            step(($urandom_range(3) != 0), $urandom_range(1023),
                 $urandom_range(1023), $urandom_range(1023), "R5");
        drain();
        step(0, 0, 0, 0, "R5");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule